// File: doc/BRIEF.md
# Split-Halfword Port Command Bridge

This block links a 32-bit register window to the command side of a network coprocessor. The coprocessor takes a 32-bit port command, but software can only deliver it as two writes to the same register. The bridge pairs those two writes and rebuilds the command word. It then splits the word into an opcode and an aligned address, and pulses a one-cycle command strobe.

The same window has two more strobe registers. One resets the coprocessor and the other raises channel attention. A fourth register reads back a fixed signature word. Only aligned, full-word accesses are accepted. Any access with a partial byte-enable or a misaligned offset is dropped. Reads have no side effects.

Top module: `split_port_bridge`

## Requirements
- R1: After reset, all strobes are low, `cmd_opcode` and `cmd_addr` are zero, `bus_rdata` is zero, and the halfword phase expects a first half.
- R2: An accepted write to offset 0x0 drives `cop_reset` high for exactly one cycle, in the cycle after the write.
- R3: The first accepted write to offset 0x4 only stores `bus_wdata[15:0]` and toggles the phase. It raises no strobe.
- R4: The second accepted write to offset 0x4 drives `cmd_valid` high for exactly one cycle, in the cycle after the write. In that cycle `cmd_addr` = {second[15:0], first[15:8], 8'h00} and `cmd_opcode` = first[7:0]. The phase then returns to first half.
- R5: Opcode values are 0x00 reset, 0x01 self-test, 0x02 alternate control-block address and 0x03 alternate dump address. Every value 0x00..0xFF passes to `cmd_opcode` unchanged.
- R6: An accepted write to offset 0x0 also returns the phase to first half. A pending first half is therefore discarded.
- R7: An accepted write to offset 0x8 drives `cop_attn` high for exactly one cycle, in the cycle after the write.
- R8: An accepted read of offset 0xC returns 32'hBEEFBABE on `bus_rdata` in the cycle after the read.
- R9: An accepted read of offset 0x0, 0x4 or 0x8 returns `cop_status` as sampled at the read edge, in the cycle after the read. No read changes the phase or raises a strobe.
- R10: An access is accepted only when `bus_be` = 4'hF and the offset is one of 0x0, 0x4, 0x8 or 0xC. Any other access changes no state and no output.
- R11: A write to offset 0xC changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | AW | Byte offset within the window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cop_status | input | 32 | Status word from the coprocessor side |
| cop_reset | output | 1 | One-cycle coprocessor reset strobe |
| cop_attn | output | 1 | One-cycle channel-attention strobe |
| cmd_valid | output | 1 | One-cycle port command strobe |
| cmd_opcode | output | 8 | Opcode of the last command |
| cmd_addr | output | 32 | Address of the last command, bits 7:0 zero |

## Verification
Every result of this block is due one clock edge after the access that causes it. This applies to the three strobes, the command fields and the read data. The bench drives each access on a falling edge and removes it on the next falling edge. It samples the outputs at that same falling edge, half a cycle after the rising edge that registered them. One more falling edge later, it checks that each strobe has dropped, which confirms the one-cycle width. Requirements about ignored accesses are checked two ways: the strobes stay low, and a later command still pairs with the first half stored before the ignored access.

// File: rtl/split_port_bridge.sv
module split_port_bridge #(
  parameter int          AW        = 4,
  parameter logic [31:0] SIGNATURE = 32'hBEEFBABE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   cop_status,
  output logic          cop_reset,
  output logic          cop_attn,
  output logic          cmd_valid,
  output logic [7:0]    cmd_opcode,
  output logic [31:0]   cmd_addr
);
  localparam logic [AW-1:0] OFF_RST  = AW'(0);
  localparam logic [AW-1:0] OFF_PORT = AW'(4);
  localparam logic [AW-1:0] OFF_ATTN = AW'(8);
  localparam logic [AW-1:0] OFF_SIG  = AW'(12);

  logic        phase;
  logic [15:0] first_half;

  logic hit, wr_ok, rd_ok, wr_rst, wr_port, wr_attn;

  assign hit     = (bus_be == 4'hF) &&
                   (bus_addr == OFF_RST || bus_addr == OFF_PORT ||
                    bus_addr == OFF_ATTN || bus_addr == OFF_SIG);
  assign wr_ok   = bus_wr && hit;
  assign rd_ok   = bus_rd && hit;
  assign wr_rst  = wr_ok && bus_addr == OFF_RST;
  assign wr_port = wr_ok && bus_addr == OFF_PORT;
  assign wr_attn = wr_ok && bus_addr == OFF_ATTN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      first_half <= '0;
      cop_reset  <= 1'b0;
      cop_attn   <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_opcode <= '0;
      cmd_addr   <= '0;
      bus_rdata  <= '0;
    end else begin
      cop_reset <= wr_rst;
      cop_attn  <= wr_attn;
      cmd_valid <= wr_port && phase;
      if (wr_rst) begin
        phase <= 1'b0;
      end else if (wr_port) begin
        phase <= ~phase;
        if (!phase) begin
          first_half <= bus_wdata[15:0];
        end else begin
          cmd_opcode <= first_half[7:0];
          cmd_addr   <= {bus_wdata[15:0], first_half[15:8], 8'h00};
        end
      end
      if (rd_ok) bus_rdata <= (bus_addr == OFF_SIG) ? SIGNATURE : cop_status;
    end
  end

  p_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cop_reset |=> !cop_reset);
  p_attn_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cop_attn |=> !cop_attn);
  p_cmd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_cmd_needs_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_port && !phase) |=> (!cmd_valid && phase));
  p_addr_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr[7:0] == 8'h00);
  p_phase_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> !phase);
  p_signature_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && bus_addr == OFF_SIG) |=> bus_rdata == SIGNATURE);
  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !hit) |=>
      ($stable(phase) && $stable(first_half) && $stable(bus_rdata) &&
       !cop_reset && !cop_attn && !cmd_valid));
  p_sig_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == OFF_SIG) |=> ($stable(phase) && !cop_reset && !cop_attn && !cmd_valid));
endmodule

// File: tb/test_split_port_bridge.sv
module test_split_port_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0, cop_status = 32'h0;
  logic [31:0] bus_rdata, cmd_addr;
  logic [7:0]  cmd_opcode;
  logic        cop_reset, cop_attn, cmd_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  split_port_bridge i_split_port_bridge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cop_status(cop_status), .cop_reset(cop_reset),
    .cop_attn(cop_attn), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [3:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_be = 0;
  endtask

  task automatic strobes(string req, bit r, bit at, bit v);
    chk(req, {29'b0, cop_reset, cop_attn, cmd_valid}, {29'b0, r, at, v});
  endtask

  task automatic idle_low(string req);
    @(negedge clk);
    strobes(req, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] f, s;
    @(negedge clk);
    // R1 reset state
    strobes("R1", 0, 0, 0);
    chk("R1 opcode", {24'b0, cmd_opcode}, 0);
    chk("R1 addr", cmd_addr, 0);
    chk("R1 rdata", bus_rdata, 0);
    rst_n = 1'b1;
    // R1 phase expects first half: one write gives no strobe
    access(1, 4, 4'hF, 32'h0000_1111);
    strobes("R1 R3", 0, 0, 0);
    access(1, 4, 4'hF, 32'h0000_2222);
    strobes("R1 R4", 0, 0, 1);
    chk("R4 addr", cmd_addr, 32'h2222_1100);
    idle_low("R4 width");

    // R2 reset strobe
    access(1, 0, 4'hF, 32'h1234_5678);
    strobes("R2", 1, 0, 0);
    idle_low("R2 width");
    // R7 attention strobe
    access(1, 8, 4'hF, 32'h0);
    strobes("R7", 0, 1, 0);
    idle_low("R7 width");

    // R4 R5 sweep over all opcodes
    for (int i = 0; i < 256; i++) begin
      f = {8'(i ^ 8'hA5), 8'(i)};
      s = 16'(i * 16'd257 ^ 16'h1234);
      access(1, 4, 4'hF, {16'hDEAD, f});
      strobes("R3 sweep", 0, 0, 0);
      access(1, 4, 4'hF, {16'hF00D, s});
      strobes("R4 sweep", 0, 0, 1);
      chk("R5 opcode", {24'b0, cmd_opcode}, i);
      chk("R4 addr", cmd_addr, {s, f[15:8], 8'h00});
    end

    // R6 reset write discards a pending first half
    access(1, 4, 4'hF, 32'h0000_AB03);
    access(1, 0, 4'hF, 32'h0);
    strobes("R6", 1, 0, 0);
    access(1, 4, 4'hF, 32'h0000_CD02);
    strobes("R6 new first", 0, 0, 0);
    access(1, 4, 4'hF, 32'h0000_5555);
    strobes("R6 pair", 0, 0, 1);
    chk("R6 opcode", {24'b0, cmd_opcode}, 32'h02);
    chk("R6 addr", cmd_addr, 32'h5555_CD00);

    // R8 signature, R9 status reads with a pending first half
    access(1, 4, 4'hF, 32'h0000_7701);
    access(0, 12, 4'hF, 0);
    chk("R8", bus_rdata, 32'hBEEFBABE);
    for (int k = 0; k < 3; k++) begin
      cop_status = 32'h0BAD_0000 + 32'(k * 17 + 3);
      access(0, 4'(k * 4), 4'hF, 0);
      chk("R9 rdata", bus_rdata, 32'h0BAD_0000 + 32'(k * 17 + 3));
      strobes("R9 no strobe", 0, 0, 0);
    end

    // R10 partial enables and bad offsets ignored, R11 signature write ignored
    for (int b = 0; b < 15; b++) begin
      access(1, 4, 4'(b), 32'h0000_9999);
      strobes("R10 be", 0, 0, 0);
      access(1, 0, 4'(b), 0);
      strobes("R10 be rst", 0, 0, 0);
      access(0, 12, 4'(b), 0);
      chk("R10 be rd", bus_rdata, 32'h0BAD_0000 + 32'(2 * 17 + 3));
    end
    for (int a = 0; a < 16; a++) begin
      if (a % 4 != 0) begin
        access(1, 4'(a), 4'hF, 32'h0000_9999);
        strobes("R10 offset", 0, 0, 0);
      end
    end
    access(1, 12, 4'hF, 32'h0000_8888);
    strobes("R11", 0, 0, 0);
    access(1, 4, 4'hF, 32'h0000_4242);
    strobes("R9 R10 R11 pair", 0, 0, 1);
    chk("R10 opcode kept", {24'b0, cmd_opcode}, 32'h01);
    chk("R10 addr kept", cmd_addr, 32'h4242_7700);
    idle_low("R4 width end");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule